// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked on-chip request bus and an external asynchronous static RAM with a 16-bit data path and a 20-bit word address. It turns each single-beat read or write request into a strobe sequence. Every minimum time of the RAM is covered by a whole number of clock cycles. Each timing figure is a parameter in nanoseconds, and the clock period is a parameter too. Each cycle count is the ceiling of the time divided by the period, and never less than one. The fast and slow speed grades therefore differ only in parameter values.

The request side is a valid/ready channel that allows one outstanding access. A request is taken on the edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until the whole access, including recovery, has finished. A requester that keeps `req_valid` high while `req_ready` is low simply waits, holding its fields stable. Read data comes back on `rsp_valid`, a one-cycle pulse with no back-pressure. The requester must always be able to take it.

On the RAM side, the chip is selected only while the active-low select is low and the active-high select is high. Outside an access both selects sit at their inactive levels. The controller drives the data pins only during writes. For that it uses a separate drive-enable output, which the pad logic turns into a tri-state buffer.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, and whenever `req_ready` is high, the RAM is deselected (`ram_sel_n`=1, `ram_sel_p`=0) and the write strobe, output-enable strobe and all lane strobes are high. `ram_d_drive` is low and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low from that edge until the access ends. With default parameters, a write keeps `req_ready` low for 14 cycles after the accepting edge.
- R3: A read selects the chip and drives the output-enable strobe low with the write strobe high, for RD_CYC = max(ceil(T_RC), ceil(T_AA), ceil(T_OE)) cycles (14 by default). The data pins are sampled on the edge that ends that window.
- R4: Read data is returned with `rsp_valid` high for exactly one cycle, starting in the cycle after the read window. Bit 0 of `req_lanes` selects bits 7:0 and bit 1 selects bits 15:8. A lane whose bit is 0 reads as zero, so a mask of 0 returns 0.
- R5: A write has three phases: one setup cycle with the chip selected and every strobe high, then a write pulse of WP_CYC cycles with the write strobe low, then at least one recovery cycle. Lane strobes go low only inside the pulse.
- R6: A write changes only the lanes whose mask bit is 1. A write with mask 0 leaves the stored word unchanged.
- R7: `ram_d_drive` rises DRV_DLY cycles after the write strobe falls and drops one cycle after it rises, so the data is valid for at least ceil(T_DW) cycles before the end of the pulse. By default the output-enable strobe stays high during writes, so the controller never drives while the RAM drives.
- R8: `ram_a` changes only on an edge where the RAM was deselected in the preceding cycle.
- R9: WP_CYC = max(ceil(T_WP), ceil(T_AW)−1, DRV_DLY+ceil(T_DW)), which is 12 with the defaults. When KEEP_OE_LOW=1, the output-enable strobe stays low through the write, and DRV_DLY becomes ceil(T_WHZ) so that the RAM's drivers are off first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_lanes | input | 2 | Byte-lane mask, bit 0 = low byte |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ram_a | output | 20 | RAM address |
| ram_sel_n | output | 1 | Active-low chip select |
| ram_sel_p | output | 1 | Active-high chip select |
| ram_rd_en_n | output | 1 | Active-low output enable |
| ram_wr_n | output | 1 | Active-low write strobe |
| ram_lane_n | output | 2 | Active-low lane strobes, bit 0 = low byte |
| ram_d_out | output | 16 | Data toward the RAM |
| ram_d_drive | output | 1 | Enable for the data pad drivers |
| ram_d_in | input | 16 | Data from the RAM pads |

## Verification
The assertions check, on every cycle, the properties that are local in time. These are: the deselected idle state, a single cycle of `ready` low after an accept, a single-cycle response pulse, the exact width of the write pulse, the drive enable rising only inside a pulse, and address changes only after a deselected cycle. Some properties can only be seen from outside, against a behavioural RAM in the bench. That model hands back valid data only after 14 selected cycles and counts data-setup cycles. It flags bus contention and strobes outside their phases. With it, the bench scenarios show lane-masked storage, the read-back values, end-to-end latencies and the mask-0 corner case.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREC
  } acc_state_e;

  // clock cycles covering a time in ns, never fewer than one
  function automatic int ns2cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int LANES   = 2,
  parameter int RD_CYC  = 14,
  parameter int WP_CYC  = 12,
  parameter int REC_CYC = 1,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [LANES-1:0]  req_lanes,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output acc_state_e        state_q,
  output acc_state_e        state_d,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [LANES-1:0]  lanes_q,
  output logic [LANES-1:0]  lanes_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rd_last
);

  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_last   = (state_q == ST_READ) && (cnt_q == CNT_W'(RD_CYC - 1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = req_we ? ST_WSETUP : ST_READ;
      ST_READ:   if (rd_last) state_d = ST_IDLE;
      ST_WSETUP: state_d = ST_WPULSE;
      ST_WPULSE: if (cnt_q == CNT_W'(WP_CYC - 1)) state_d = ST_WREC;
      ST_WREC:   if (cnt_q == CNT_W'(REC_CYC - 1)) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign cnt_d   = (state_d != state_q) ? '0 : cnt_q + 1'b1;
  assign lanes_d = accept ? req_lanes : lanes_q;
  assign addr_d  = accept ? req_addr  : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lanes_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lanes_q <= lanes_d;
      addr_q  <= addr_d;
      if (accept) wdata_q <= req_wdata;
    end
  end

endmodule

// File: rtl/sram_strobe_gen.sv
`timescale 1ns/1ps
module sram_strobe_gen
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int LANES       = 2,
  parameter bit KEEP_OE_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_state_e        state_d,
  input  logic [LANES-1:0]  lanes_d,
  input  logic [ADDR_W-1:0] addr_d,
  output logic [ADDR_W-1:0] ram_a,
  output logic              ram_sel_n,
  output logic              ram_sel_p,
  output logic              ram_rd_en_n,
  output logic              ram_wr_n,
  output logic [LANES-1:0]  ram_lane_n
);

  logic sel_d, oe_d, lane_phase_d;

  assign sel_d        = (state_d != ST_IDLE);
  assign oe_d         = (state_d == ST_READ) || (KEEP_OE_LOW && sel_d);
  assign lane_phase_d = (state_d == ST_READ) || (state_d == ST_WPULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_a       <= '0;
      ram_sel_n   <= 1'b1;
      ram_sel_p   <= 1'b0;
      ram_rd_en_n <= 1'b1;
      ram_wr_n    <= 1'b1;
    end else begin
      ram_a       <= addr_d;
      ram_sel_n   <= !sel_d;
      ram_sel_p   <= sel_d;
      ram_rd_en_n <= !oe_d;
      ram_wr_n    <= (state_d != ST_WPULSE);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ram_lane_n[i] <= 1'b1;
      else        ram_lane_n[i] <= !(lanes_d[i] && lane_phase_d);
    end
  end

endmodule

// File: rtl/sram_data_path.sv
`timescale 1ns/1ps
module sram_data_path
  import sram_lane_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LANES   = 2,
  parameter int DRV_DLY = 1,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_state_e        state_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [LANES-1:0]  lanes_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              rd_last,
  input  logic [DATA_W-1:0] ram_d_in,
  output logic [DATA_W-1:0] ram_d_out,
  output logic              ram_d_drive,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LANE_W = DATA_W / LANES;

  assign ram_d_out   = wdata_q;
  assign ram_d_drive = ((state_q == ST_WPULSE) && (cnt_q >= CNT_W'(DRV_DLY)))
                    || ((state_q == ST_WREC) && (cnt_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rd_last;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsp_rdata[i*LANE_W +: LANE_W] <= '0;
      end else if (rd_last) begin
        rsp_rdata[i*LANE_W +: LANE_W] <= lanes_q[i] ? ram_d_in[i*LANE_W +: LANE_W] : '0;
      end
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int CLK_NS      = 4,
  parameter int T_RC        = 55,
  parameter int T_AA        = 55,
  parameter int T_OE        = 30,
  parameter int T_WC        = 55,
  parameter int T_WP        = 45,
  parameter int T_AW        = 50,
  parameter int T_DW        = 25,
  parameter int T_WHZ       = 20,
  parameter bit KEEP_OE_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [DATA_W/8-1:0] req_lanes,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_a,
  output logic              ram_sel_n,
  output logic              ram_sel_p,
  output logic              ram_rd_en_n,
  output logic              ram_wr_n,
  output logic [DATA_W/8-1:0] ram_lane_n,
  output logic [DATA_W-1:0] ram_d_out,
  output logic              ram_d_drive,
  input  logic [DATA_W-1:0] ram_d_in
);

  localparam int LANES   = DATA_W / 8;
  localparam int RD_CYC  = max2(max2(ns2cyc(T_RC, CLK_NS), ns2cyc(T_AA, CLK_NS)),
                                ns2cyc(T_OE, CLK_NS));
  localparam int DRV_DLY = KEEP_OE_LOW ? ns2cyc(T_WHZ, CLK_NS) : 1;
  localparam int WP_CYC  = max2(max2(ns2cyc(T_WP, CLK_NS), ns2cyc(T_AW, CLK_NS) - 1),
                                DRV_DLY + ns2cyc(T_DW, CLK_NS));
  localparam int REC_CYC = max2(1, ns2cyc(T_WC, CLK_NS) - 1 - WP_CYC);
  localparam int CNT_W   = $clog2(max2(RD_CYC, WP_CYC) + 1);

  acc_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [LANES-1:0]  lanes_q, lanes_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_q;
  logic              rd_last;

  sram_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
    .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_lanes(req_lanes),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .state_q(state_q), .state_d(state_d), .cnt_q(cnt_q),
    .lanes_q(lanes_q), .lanes_d(lanes_d), .addr_d(addr_d),
    .wdata_q(wdata_q), .rd_last(rd_last)
  );

  sram_strobe_gen #(
    .ADDR_W(ADDR_W), .LANES(LANES), .KEEP_OE_LOW(KEEP_OE_LOW)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n),
    .state_d(state_d), .lanes_d(lanes_d), .addr_d(addr_d),
    .ram_a(ram_a), .ram_sel_n(ram_sel_n), .ram_sel_p(ram_sel_p),
    .ram_rd_en_n(ram_rd_en_n), .ram_wr_n(ram_wr_n), .ram_lane_n(ram_lane_n)
  );

  sram_data_path #(
    .DATA_W(DATA_W), .LANES(LANES), .DRV_DLY(DRV_DLY), .CNT_W(CNT_W)
  ) u_data (
    .clk(clk), .rst_n(rst_n),
    .state_q(state_q), .cnt_q(cnt_q), .lanes_q(lanes_q), .wdata_q(wdata_q),
    .rd_last(rd_last), .ram_d_in(ram_d_in),
    .ram_d_out(ram_d_out), .ram_d_drive(ram_d_drive),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk #(
  parameter int ADDR_W      = 20,
  parameter int WP_CYC      = 12,
  parameter bit KEEP_OE_LOW = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] ram_a,
  input logic              ram_sel_n,
  input logic              ram_sel_p,
  input logic              ram_rd_en_n,
  input logic              ram_wr_n,
  input logic              ram_d_drive
);

  logic [7:0] wlow_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wlow_cnt <= '0;
    else if (!ram_wr_n) wlow_cnt <= wlow_cnt + 1'b1;
    else                wlow_cnt <= '0;
  end

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_sel_n && !ram_sel_p && ram_wr_n && !ram_d_drive));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_wr_n) |-> (wlow_cnt == 8'(WP_CYC)));

  // R5
  setup_before_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_wr_n) |-> $past(!ram_sel_n && ram_sel_p));

  // R7
  drive_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_d_drive) |-> (!ram_wr_n && $past(!ram_wr_n)));

  // R7
  no_oe_while_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_d_drive && !KEEP_OE_LOW) |-> ram_rd_en_n);

  // R8
  addr_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ram_a) |-> $past(ram_sel_n));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W(ADDR_W), .WP_CYC(WP_CYC), .KEEP_OE_LOW(KEEP_OE_LOW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .ram_a(ram_a), .ram_sel_n(ram_sel_n),
  .ram_sel_p(ram_sel_p), .ram_rd_en_n(ram_rd_en_n), .ram_wr_n(ram_wr_n),
  .ram_d_drive(ram_d_drive)
);

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;

  localparam int RD_EXP  = 14;               // ceil(55/4)
  localparam int WP_EXP  = 12;               // max(ceil(45/4), ceil(50/4)-1, 1+ceil(25/4))
  localparam int DS_MIN  = 7;                // ceil(25/4)
  localparam int LAT_EXP = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [1:0]  req_lanes = '0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] ram_a;
  logic        ram_sel_n, ram_sel_p, ram_rd_en_n, ram_wr_n, ram_d_drive;
  logic [1:0]  ram_lane_n;
  logic [15:0] ram_d_out, ram_d_in;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sram_lane_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_lanes(req_lanes), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ram_a(ram_a), .ram_sel_n(ram_sel_n), .ram_sel_p(ram_sel_p),
    .ram_rd_en_n(ram_rd_en_n), .ram_wr_n(ram_wr_n), .ram_lane_n(ram_lane_n),
    .ram_d_out(ram_d_out), .ram_d_drive(ram_d_drive), .ram_d_in(ram_d_in)
  );

  // behavioural RAM: 16 words, valid read data only after RD_EXP selected cycles
  logic [15:0] mem [16];
  int rd_cnt = 0, wl_cnt = 0, ds_cnt = 0, last_wp = 0, last_ds = 0;
  int n_contend = 0, n_oelow = 0, n_lane = 0, n_addr = 0;
  logic [15:0] wbuf = '0;
  logic [1:0]  wlanes = 2'b11;
  logic [19:0] prev_addr = '0;
  bit          prev_active = 1'b0;
  logic        sel;
  logic [1:0]  drive;

  assign sel = !ram_sel_n && ram_sel_p;
  assign drive[0] = sel && ram_wr_n && !ram_rd_en_n && !ram_lane_n[0];
  assign drive[1] = sel && ram_wr_n && !ram_rd_en_n && !ram_lane_n[1];
  assign ram_d_in[7:0]  = drive[0] ? ((rd_cnt >= RD_EXP) ? mem[ram_a[3:0]][7:0]  : 8'hEE) : 8'h5A;
  assign ram_d_in[15:8] = drive[1] ? ((rd_cnt >= RD_EXP) ? mem[ram_a[3:0]][15:8] : 8'hEE) : 8'h5A;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      rd_cnt = 0; wl_cnt = 0; ds_cnt = 0;
      prev_addr = '0; prev_active = 1'b0;
    end else begin
      if (sel && ram_wr_n && !ram_rd_en_n) rd_cnt++; else rd_cnt = 0;
      if ((|drive) && ram_d_drive) n_contend++;
      if (sel && !ram_wr_n && !ram_rd_en_n) n_oelow++;
      if (sel && ram_wr_n && ram_rd_en_n && !(&ram_lane_n)) n_lane++;
      if (ram_a != prev_addr && prev_active) n_addr++;
      prev_addr   = ram_a;
      prev_active = sel && (!ram_wr_n || !(&ram_lane_n));
      if (sel && !ram_wr_n) begin
        wl_cnt++;
        wlanes = ram_lane_n;
        if (ram_d_drive) begin ds_cnt++; wbuf = ram_d_out; end
      end else if (wl_cnt > 0) begin
        if (ds_cnt > 0 && !wlanes[0]) mem[ram_a[3:0]][7:0]  = wbuf[7:0];
        if (ds_cnt > 0 && !wlanes[1]) mem[ram_a[3:0]][15:8] = wbuf[15:8];
        last_wp = wl_cnt; last_ds = ds_cnt;
        wl_cnt = 0; ds_cnt = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic run_req(input bit we, input logic [1:0] ln, input logic [3:0] a,
                         input logic [15:0] d, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_lanes = ln;
    req_addr = {16'h0, a}; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    rd = '0;
    if (we) begin
      while (!req_ready) begin @(negedge clk); lat++; end
    end else begin
      while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
      rd = rsp_rdata;
      @(negedge clk);
      chk(!rsp_valid, "R4 pulse one cycle", rsp_valid, 0);
    end
  endtask

  // {we, lanes, addr, wdata, expected read}
  localparam logic [38:0] VEC [10] = '{
    {1'b1, 2'b11, 4'h1, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 4'h1, 16'h0000, 16'h1234},
    {1'b1, 2'b01, 4'h1, 16'hABCD, 16'h0000},
    {1'b0, 2'b11, 4'h1, 16'h0000, 16'h12CD},
    {1'b1, 2'b10, 4'h2, 16'h7788, 16'h0000},
    {1'b0, 2'b11, 4'h2, 16'h0000, 16'h7700},
    {1'b0, 2'b01, 4'h1, 16'h0000, 16'h00CD},
    {1'b1, 2'b00, 4'h1, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 4'h1, 16'h0000, 16'h12CD},
    {1'b0, 2'b10, 4'h2, 16'h0000, 16'h7700}
  };

  initial begin
    logic [15:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ram_sel_n && !ram_sel_p && ram_rd_en_n && ram_wr_n && (&ram_lane_n),
        "R1 strobes in reset", {ram_sel_n, ram_sel_p, ram_rd_en_n, ram_wr_n, ram_lane_n}, 6'b101111);
    chk(!ram_d_drive && !rsp_valid, "R1 drive/rsp in reset", {ram_d_drive, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    for (int k = 0; k < 10; k++) begin
      logic [38:0] v;
      v = VEC[k];
      run_req(v[38], v[37:36], v[35:32], v[31:16], rd, lat);
      if (v[38]) begin
        chk(lat == LAT_EXP, "R2 write busy length", lat, LAT_EXP);
        chk(last_wp == WP_EXP, "R5 write pulse width", last_wp, WP_EXP);
        chk(last_ds >= DS_MIN, "R7 data setup cycles", last_ds, DS_MIN);
      end else begin
        chk(lat == LAT_EXP, "R3 read latency", lat, LAT_EXP);
        chk(rd == v[15:0], "R4/R6 read data", rd, v[15:0]);
      end
    end

    // R9: pulse width follows the ceiling formula with a 4 ns clock
    chk(last_wp == (50 + 3) / 4 - 1, "R9 derived pulse count", last_wp, (50 + 3) / 4 - 1);
    // R4 mask 0 read returns zero
    run_req(1'b0, 2'b00, 4'h2, 16'h0, rd, lat);
    chk(rd == 16'h0, "R4 mask-0 read", rd, 0);
    // R6 mask-0 write leaves word intact
    run_req(1'b1, 2'b00, 4'h2, 16'hFFFF, rd, lat);
    run_req(1'b0, 2'b11, 4'h2, 16'h0, rd, lat);
    chk(rd == 16'h7700, "R6 mask-0 write no effect", rd, 16'h7700);

    chk(n_contend == 0, "R7 no bus contention", n_contend, 0);
    chk(n_oelow == 0, "R7 output enable high in writes", n_oelow, 0);
    chk(n_lane == 0, "R5 lanes only inside pulse", n_lane, 0);
    chk(n_addr == 0, "R8 address stable while active", n_addr, 0);
    @(negedge clk);
    chk(ram_sel_n && !ram_sel_p && req_ready, "R1 idle after accesses",
        {ram_sel_n, ram_sel_p, req_ready}, 3'b101);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule